// File: doc/BRIEF.md
# Paged Sensor Register Bank

This block is a byte-wide register file that a host reaches through a plain parallel bus. The bus carries a 6-bit offset, one write strobe, one read strobe and 8-bit data in each direction. There are 128 absolute locations, split into two pages of 64. A one-bit page register decides which page the offset lands in, so the absolute location is the page times 64 plus the offset. Offset 0x3F always reaches the page register, on either page. The host can therefore always return to page 0.

The lower page holds the live view of the sensor: a status byte with the data-ready flag, the 16-bit temperature sample and the 24-bit angular-rate sample. The upper page holds two fixed device identifiers and six factory identifier bytes set by a parameter. It also holds five writable control bytes: source select, sync control, two divider bytes and bandwidth control. Their stored values drive output ports for the neighbouring logic.

A read of the rate low byte captures the two upper rate bytes in a shadow register. Later reads of the middle and high bytes then return the same sample, and the host never sees a torn 24-bit value.

Top module: `prb_bank`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `rdata_o` is 0x00, the active page is 0 and all control outputs are zero.
- R2: A write at offset 0x3F on either page sets the page to `wdata_i[0]` and ignores the other bits. A read at offset 0x3F on either page returns `{7'b0, page}`, so absolute 0x7F aliases to the page register.
- R3: On page 0, offset N reaches absolute N. On page 1, offset N reaches absolute 0x40+N. Page 0 writes never change a control output.
- R4: Absolute 0x2E reads `drdy_i` in bit 6, with every other bit at 0.
- R5: Absolute 0x30 reads `temp_i[7:0]` and absolute 0x31 reads `temp_i[15:8]`, both live.
- R6: Absolute 0x32 reads `rate_i[7:0]` live and, in the same cycle, latches `rate_i[23:8]` into a shadow. Absolute 0x33 and 0x34 return shadow bits [15:8] and [23:16] of the last such capture, or 0x00 if there has been none since reset.
- R7: Absolute 0x49 reads 0x41 and absolute 0x4A reads 0x01. Writes to them have no effect.
- R8: Absolute 0x4C+k, for k from 0 to 5, reads byte k (bits 8k+7 to 8k) of the `FACTORY_ID` parameter. These bytes are read-only.
- R9: The control bytes store all 8 bits and read back what was written: 0x59 drives `src_sel_o`, 0x6A drives `sync_ctrl_o`, 0x6B drives `sync_div_o[7:0]`, 0x6C drives `sync_div_o[15:8]` and 0x6D drives `bw_ctrl_o`.
- R10: A read of an unmapped absolute address returns 0x00. A write to a read-only or unmapped address changes no readable value and no output.
- R11: `rdata_o` is registered. It takes the addressed value at the clock edge where `rd_i` is high and holds it while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ofs_i | input | 6 | Bus offset within the active page |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| drdy_i | input | 1 | Sensor data-ready flag |
| rate_i | input | 24 | Sensor rate sample |
| temp_i | input | 16 | Sensor temperature sample |
| src_sel_o | output | 8 | Source-select control byte |
| sync_ctrl_o | output | 8 | Sync control byte |
| sync_div_o | output | 16 | Sync divider, high byte and low byte |
| bw_ctrl_o | output | 8 | Bandwidth control byte |

## Verification
Some rules hold on every cycle, and the assertions check them there. These are the page register update and readback at offset 0x3F, the status byte layout, the fixed identifier and the hold of read data between strobes. The checker also requires that page 0 writes leave the control outputs untouched. Only the bench's scenarios can show the shadow capture keeping a rate sample whole across a later change of `rate_i`, the byte order of the factory identifier, and the way writes to read-only locations are ignored. Each of these depends on a sequence of accesses and a value chosen in advance.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int ADR_STATUS = 'h2E;
  localparam int DRDY_BIT   = 6;
  localparam int ADR_TEMP   = 'h30;
  localparam int ADR_RATE   = 'h32;
  localparam int ADR_CHIP1  = 'h49;
  localparam int ADR_CHIP2  = 'h4A;
  localparam int CHIP1_VAL  = 'h41;
  localparam int CHIP2_VAL  = 'h01;
  localparam int ADR_FID    = 'h4C;
  localparam int NUM_CTRL   = 5;

  // control byte order: source select, sync control, divider low, divider high, bandwidth
  function automatic int ctrl_adr(input int idx);
    case (idx)
      0:       return 'h59;
      1:       return 'h6A;
      2:       return 'h6B;
      3:       return 'h6C;
      default: return 'h6D;
    endcase
  endfunction
endpackage

// File: rtl/prb_page.sv
module prb_page #(
  parameter int OFS_W = 6,
  localparam int ABS_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             wr_i,
  input  logic             wbit_i,
  output logic             page_o,
  output logic             sel_hit_o,
  output logic [ABS_W-1:0] abs_o
);
  logic page_q;

  assign sel_hit_o = &ofs_i;
  assign abs_o     = {page_q, ofs_i};
  assign page_o    = page_q;

  always_ff @(posedge clk) begin
    if (rst)
      page_q <= 1'b0;
    else if (wr_i && sel_hit_o)
      page_q <= wbit_i;
  end
endmodule

// File: rtl/prb_ctrl_regs.sv
module prb_ctrl_regs
  import prb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ABS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [ABS_W-1:0] abs_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [DW-1:0]    src_sel_o,
  output logic [DW-1:0]    sync_ctrl_o,
  output logic [2*DW-1:0]  sync_div_o,
  output logic [DW-1:0]    bw_ctrl_o
);
  logic [DW-1:0] regs_q [NUM_CTRL];

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= '0;
      else if (wr_i && abs_i == ABS_W'(ctrl_adr(g)))
        regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_CTRL; k++)
      if (abs_i == ABS_W'(ctrl_adr(k)))
        rd_data_o = regs_q[k];
  end

  assign src_sel_o   = regs_q[0];
  assign sync_ctrl_o = regs_q[1];
  assign sync_div_o  = {regs_q[3], regs_q[2]};
  assign bw_ctrl_o   = regs_q[4];
endmodule

// File: rtl/prb_sensor_rd.sv
module prb_sensor_rd
  import prb_pkg::*;
#(
  parameter int DW         = 8,
  parameter int ABS_W      = 7,
  parameter int RATE_W     = 24,
  parameter int TEMP_W     = 16,
  parameter int ID_BYTES   = 6,
  parameter logic [ID_BYTES*DW-1:0] FACTORY_ID = '0,
  localparam int RATE_BYTES = RATE_W / DW,
  localparam int TEMP_BYTES = TEMP_W / DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ABS_W-1:0]  abs_i,
  input  logic              drdy_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [DW-1:0]     rd_data_o
);
  logic [RATE_W-1:DW] shadow_q;
  logic [RATE_W-1:0]  rate_view;

  // upper rate bytes captured on a read of the low byte
  always_ff @(posedge clk) begin
    if (rst)
      shadow_q <= '0;
    else if (rd_i && abs_i == ABS_W'(ADR_RATE))
      shadow_q <= rate_i[RATE_W-1:DW];
  end

  assign rate_view = {shadow_q, rate_i[DW-1:0]};

  always_comb begin
    rd_data_o = '0;
    if (abs_i == ABS_W'(ADR_STATUS))
      rd_data_o[DRDY_BIT] = drdy_i;
    if (abs_i == ABS_W'(ADR_CHIP1))
      rd_data_o = DW'(CHIP1_VAL);
    if (abs_i == ABS_W'(ADR_CHIP2))
      rd_data_o = DW'(CHIP2_VAL);
    for (int k = 0; k < TEMP_BYTES; k++)
      if (abs_i == ABS_W'(ADR_TEMP + k))
        rd_data_o = temp_i[k*DW +: DW];
    for (int k = 0; k < RATE_BYTES; k++)
      if (abs_i == ABS_W'(ADR_RATE + k))
        rd_data_o = rate_view[k*DW +: DW];
    for (int k = 0; k < ID_BYTES; k++)
      if (abs_i == ABS_W'(ADR_FID + k))
        rd_data_o = FACTORY_ID[k*DW +: DW];
  end
endmodule

// File: rtl/prb_bank.sv
module prb_bank #(
  parameter int OFS_W    = 6,
  parameter int DW       = 8,
  parameter int RATE_W   = 24,
  parameter int TEMP_W   = 16,
  parameter int ID_BYTES = 6,
  parameter logic [ID_BYTES*DW-1:0] FACTORY_ID = 48'h0605_0403_0201,
  localparam int ABS_W = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              drdy_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [DW-1:0]     src_sel_o,
  output logic [DW-1:0]     sync_ctrl_o,
  output logic [2*DW-1:0]   sync_div_o,
  output logic [DW-1:0]     bw_ctrl_o
);
  logic             page_q;
  logic             sel_hit;
  logic [ABS_W-1:0] abs_adr;
  logic [DW-1:0]    ctrl_data;
  logic [DW-1:0]    sens_data;

  prb_page #(.OFS_W(OFS_W)) u_page (
    .clk       (clk),
    .rst       (rst),
    .ofs_i     (ofs_i),
    .wr_i      (wr_i),
    .wbit_i    (wdata_i[0]),
    .page_o    (page_q),
    .sel_hit_o (sel_hit),
    .abs_o     (abs_adr)
  );

  prb_ctrl_regs #(.DW(DW), .ABS_W(ABS_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (wr_i),
    .abs_i       (abs_adr),
    .wdata_i     (wdata_i),
    .rd_data_o   (ctrl_data),
    .src_sel_o   (src_sel_o),
    .sync_ctrl_o (sync_ctrl_o),
    .sync_div_o  (sync_div_o),
    .bw_ctrl_o   (bw_ctrl_o)
  );

  prb_sensor_rd #(
    .DW(DW), .ABS_W(ABS_W), .RATE_W(RATE_W), .TEMP_W(TEMP_W),
    .ID_BYTES(ID_BYTES), .FACTORY_ID(FACTORY_ID)
  ) u_sens (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (rd_i),
    .abs_i     (abs_adr),
    .drdy_i    (drdy_i),
    .rate_i    (rate_i),
    .temp_i    (temp_i),
    .rd_data_o (sens_data)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata_o <= '0;
    else if (rd_i)
      rdata_o <= sel_hit ? DW'(page_q) : (ctrl_data | sens_data);
  end
endmodule

// File: rtl/prb_chk.sv
module prb_chk #(
  parameter int OFS_W = 6,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [OFS_W-1:0] ofs_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             drdy_i,
  input logic             page_q,
  input logic [DW-1:0]    src_sel_o,
  input logic [DW-1:0]    sync_ctrl_o,
  input logic [2*DW-1:0]  sync_div_o,
  input logic [DW-1:0]    bw_ctrl_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rdata_o == '0 && page_q == 1'b0 && src_sel_o == '0 && sync_div_o == '0));

  // R2
  page_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (&ofs_i)) |=> (page_q == $past(wdata_i[0])));

  // R2
  page_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (&ofs_i)) |=> (rdata_o == DW'($past(page_q))));

  // R3
  page0_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !page_q) |=> ($stable(src_sel_o) && $stable(sync_ctrl_o) &&
                           $stable(sync_div_o) && $stable(bw_ctrl_o)));

  // R4
  status_layout_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !page_q && ofs_i == OFS_W'('h2E)) |=> (rdata_o == DW'({$past(drdy_i), 6'b0})));

  // R7
  chip_id_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && page_q && ofs_i == OFS_W'('h09)) |=> (rdata_o == DW'('h41)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

bind prb_bank prb_chk #(.OFS_W(OFS_W), .DW(DW)) u_prb_chk (
  .clk         (clk),
  .rst         (rst),
  .ofs_i       (ofs_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .drdy_i      (drdy_i),
  .page_q      (page_q),
  .src_sel_o   (src_sel_o),
  .sync_ctrl_o (sync_ctrl_o),
  .sync_div_o  (sync_div_o),
  .bw_ctrl_o   (bw_ctrl_o)
);

// File: tb/prb_bank_test.sv
`timescale 1ns/1ps
module prb_bank_test;
  localparam logic [47:0] FID = 48'hA1B2_C3D4_E5F6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  ofs = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic        drdy = 1'b0;
  logic [23:0] rate = '0;
  logic [15:0] temp = '0;
  logic [7:0]  rdata_o, src_sel_o, sync_ctrl_o, bw_ctrl_o;
  logic [15:0] sync_div_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prb_bank #(.FACTORY_ID(FID)) uut (
    .clk(clk), .rst(rst), .ofs_i(ofs), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata_o), .drdy_i(drdy), .rate_i(rate), .temp_i(temp),
    .src_sel_o(src_sel_o), .sync_ctrl_o(sync_ctrl_o), .sync_div_o(sync_div_o),
    .bw_ctrl_o(bw_ctrl_o)
  );

  // behavioural reference model
  bit        m_page;
  int        m_rdata;
  int        m_shadow;
  int        m_reg [int];

  function automatic bit is_rw(input int a);
    return a == 'h59 || a == 'h6A || a == 'h6B || a == 'h6C || a == 'h6D;
  endfunction

  function automatic int model_read(input int a, input int o);
    if (o == 63) return int'(m_page);
    if (is_rw(a)) return m_reg.exists(a) ? m_reg[a] : 0;
    if (a >= 'h4C && a <= 'h51) return int'((FID >> (8 * (a - 'h4C))) & 48'hFF);
    case (a)
      'h2E: return drdy ? 'h40 : 0;
      'h30: return int'(temp[7:0]);
      'h31: return int'(temp[15:8]);
      'h32: return int'(rate[7:0]);
      'h33: return m_shadow & 'hFF;
      'h34: return (m_shadow >> 8) & 'hFF;
      'h49: return 'h41;
      'h4A: return 'h01;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int a;
    a = (m_page ? 64 : 0) + int'(ofs);
    if (rst) begin
      m_page = 0; m_rdata = 0; m_shadow = 0; m_reg.delete();
    end else begin
      if (rd) begin
        m_rdata = model_read(a, int'(ofs));
        if (a == 'h32) m_shadow = int'(rate[23:8]);
      end
      if (wr) begin
        if (ofs == 6'h3F) m_page = wdata[0];
        else if (is_rw(a)) m_reg[a] = int'(wdata);
      end
    end
  end

  function automatic int mreg(input int a);
    return m_reg.exists(a) ? m_reg[a] : 0;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R11 rdata vs model", int'(rdata_o), m_rdata);
      check("R9 src_sel vs model", int'(src_sel_o), mreg('h59));
      check("R9 sync_ctrl vs model", int'(sync_ctrl_o), mreg('h6A));
      check("R9 sync_div vs model", int'(sync_div_o), mreg('h6B) + 256 * mreg('h6C));
      check("R9 bw_ctrl vs model", int'(bw_ctrl_o), mreg('h6D));
    end
  end

  task automatic bus_wr(input logic [5:0] o, input logic [7:0] d);
    @(negedge clk); ofs = o; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] o, output int v);
    @(negedge clk); ofs = o; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = int'(rdata_o);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", int'(rdata_o), 0);
    check("R1 src_sel", int'(src_sel_o), 0);
    check("R1 sync_div", int'(sync_div_o), 0);
    rst = 1'b0;

    // R2 page register
    bus_rd(6'h3F, v); check("R2 page after reset", v, 0);
    bus_wr(6'h3F, 8'hFF);
    bus_rd(6'h3F, v); check("R2 page keeps bit0", v, 1);

    // R9 control bytes on page 1
    bus_wr(6'h19, 8'hA5);
    bus_wr(6'h2A, 8'h5C);
    bus_wr(6'h2B, 8'h34);
    bus_wr(6'h2C, 8'h12);
    bus_wr(6'h2D, 8'hC3);
    check("R9 src_sel out", int'(src_sel_o), 'hA5);
    check("R9 sync_ctrl out", int'(sync_ctrl_o), 'h5C);
    check("R9 sync_div out", int'(sync_div_o), 'h1234);
    check("R9 bw_ctrl out", int'(bw_ctrl_o), 'hC3);
    bus_rd(6'h19, v); check("R9 src_sel readback", v, 'hA5);
    bus_rd(6'h2D, v); check("R9 bw_ctrl readback", v, 'hC3);

    // R7 fixed identifiers
    bus_rd(6'h09, v); check("R7 id1", v, 'h41);
    bus_rd(6'h0A, v); check("R7 id2", v, 'h01);
    bus_wr(6'h09, 8'hFF);
    bus_rd(6'h09, v); check("R7 id1 after write", v, 'h41);

    // R8 factory identifier bytes
    for (int k = 0; k < 6; k++) begin
      bus_rd(6'(12 + k), v);
      check("R8 factory byte", v, int'((FID >> (8 * k)) & 48'hFF));
    end
    bus_wr(6'h0C, 8'h00);
    bus_rd(6'h0C, v); check("R8 factory byte after write", v, 'hF6);

    // R10 unmapped
    bus_wr(6'h00, 8'h99);
    bus_rd(6'h00, v); check("R10 unmapped read", v, 0);
    bus_rd(6'h3F, v); check("R2 alias 0x7F", v, 1);

    // R3 back to page 0
    bus_wr(6'h3F, 8'hFE);
    bus_rd(6'h3F, v); check("R2 page cleared", v, 0);
    bus_wr(6'h19, 8'h77);
    check("R3 page0 write leaves src_sel", int'(src_sel_o), 'hA5);
    bus_rd(6'h19, v); check("R3 page0 offset 0x19 unmapped", v, 0);

    // R4 status
    drdy = 1'b1;
    bus_rd(6'h2E, v); check("R4 status ready", v, 'h40);
    drdy = 1'b0;
    bus_rd(6'h2E, v); check("R4 status not ready", v, 0);

    // R5 temperature
    temp = 16'hBEEF;
    bus_rd(6'h30, v); check("R5 temp low", v, 'hEF);
    bus_rd(6'h31, v); check("R5 temp high", v, 'hBE);

    // R6 rate shadow
    bus_rd(6'h33, v); check("R6 shadow before capture", v, 0);
    rate = 24'h123456;
    bus_rd(6'h32, v); check("R6 rate low", v, 'h56);
    rate = 24'hABCDEF;
    bus_rd(6'h33, v); check("R6 rate mid from shadow", v, 'h34);
    bus_rd(6'h34, v); check("R6 rate high from shadow", v, 'h12);
    bus_rd(6'h32, v); check("R6 rate low new", v, 'hEF);
    bus_rd(6'h34, v); check("R6 rate high new", v, 'hAB);

    // R11 hold between reads
    temp = 16'h0000; rate = 24'h0;
    bus_rd(6'h31, v);
    repeat (4) @(negedge clk);
    check("R11 rdata held", int'(rdata_o), 0);
    temp = 16'h5A00;
    repeat (3) @(negedge clk);
    check("R11 rdata unchanged by input", int'(rdata_o), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule